// File: doc/BRIEF.md
# Big-Endian Byte and Word Load-Store Unit

This block connects a 32-bit register datapath to a word-organised data memory, which is kept inside the block. It serves four requests: word load, word store, byte load and byte store. Each request supplies a base value, a signed 16-bit displacement, store data and a 6-bit operation code. The block adds the base and the displacement to form the effective byte address. It selects the memory word and the byte lane, and it drives per-byte write strobes into a synchronous RAM.

Byte lanes are numbered big-endian: the lowest byte address inside a word is the most significant byte. A byte load extracts the selected lane and sign-extends it to 32 bits. A byte store changes one lane and leaves the other three untouched, with no read-modify-write cycle. A word access to an address that is not a multiple of four raises a flag. It does not trap: the access performs no write and returns no load result.

Top module: `lsu_be_top`

## Requirements
- R1: `eff_addr` equals `base_val` plus `offset_imm` sign-extended to 32 bits, with no registers in between. The RAM word index is `eff_addr[AW+1:2]`.
- R2: Operation codes are 35 for word load, 43 for word store, 32 for byte load and 40 for byte store. Any other code, or `req_valid` low, writes nothing and produces no load result.
- R3: A byte load returns the lane picked by `eff_addr[1:0]`, with offset 0 taken from bits 31:24, offset 1 from 23:16, offset 2 from 15:8 and offset 3 from 7:0. The lane lands in bits 7:0 and its bit 7 is copied into bits 31:8.
- R4: A byte store raises exactly one bit of `mem_byte_we`. Bit i guards memory bits 8i+7:8i, so offset 0 drives bit 3 and offset 3 drives bit 0. It writes `store_data[7:0]` into that lane only and leaves the other three bytes unchanged.
- R5: An aligned word store raises all four `mem_byte_we` bits and writes the whole `store_data`. An aligned word load returns the whole stored word.
- R6: A word access with `eff_addr[1:0]` not equal to zero raises `misaligned` in the same cycle. It writes nothing and produces no load result.
- R7: A load result appears with `load_valid` high for exactly one cycle, one clock after the accepted load request.
- R8: After a synchronous active-low reset, `load_valid` is low. With no request, `misaligned` and `mem_byte_we` are zero.
- R9: A byte access never raises `misaligned`, whatever its offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 6 | Operation code |
| base_val | input | 32 | Base register value |
| offset_imm | input | 16 | Signed displacement |
| store_data | input | 32 | Source register value for stores |
| eff_addr | output | 32 | Effective byte address |
| mem_byte_we | output | 4 | Byte write strobes into the RAM |
| misaligned | output | 1 | Word access not on a 4-byte boundary |
| load_valid | output | 1 | Load result present |
| load_data | output | 32 | Extended load result |

## Verification
On every cycle the assertions check the following: a byte store raises exactly one strobe, a misaligned access has no strobes, and a byte access never reports misalignment. They also check that `load_valid` follows an aligned load one cycle later and stays low after idle cycles, and that a byte result is sign-extended. Only the directed scenarios can show that the right lane holds the right value and that neighbouring bytes survive a byte store. The same applies to negative displacements reaching the correct word and to misaligned or unknown requests leaving memory intact, because these depend on stored data over several requests.

// File: rtl/lsu_pkg.sv
// Package: shared operation codes and lane helpers for the load-store unit.
// Assumes 32-bit words of four bytes, numbered big-endian.
package lsu_pkg;
    typedef enum logic [5:0] {
        OP_LD_WORD  = 6'd35,
        OP_ST_WORD  = 6'd43,
        OP_LD_BYTE  = 6'd32,
        OP_ST_BYTE  = 6'd40
    } lsu_op_e;

    localparam int unsigned LANES = 4;

    // Strobe for a big-endian byte offset: offset 0 is the most significant lane.
    function automatic logic [LANES-1:0] lane_strobe(input logic [1:0] ofs);
        return 4'b1000 >> ofs;
    endfunction
endpackage

// File: rtl/lsu_addr_gen.sv
// Module: lsu_addr_gen
// Forms the effective address and decodes the operation. Produces the write
// strobes, the aligned write data and the misalignment flag.
// Assumes one request per cycle. All outputs are combinational on the request.
module lsu_addr_gen
    import lsu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [5:0]  req_op,
    input  logic [31:0] base_val,
    input  logic [15:0] offset_imm,
    input  logic [31:0] store_data,
    output logic [31:0] ea,
    output logic [3:0]  byte_we,
    output logic [31:0] wr_data,
    output logic        misalign,
    output logic        load_go,
    output logic        load_is_byte
);
    logic is_ldw, is_stw, is_ldb, is_stb, word_op, bad_align;

    // Purpose: add the base and the sign-extended displacement.
    always_comb begin
        ea = base_val + {{16{offset_imm[15]}}, offset_imm};
    end

    // Purpose: decode the operation and gate the strobes with alignment.
    always_comb begin
        is_ldw    = req_valid && (req_op == OP_LD_WORD);
        is_stw    = req_valid && (req_op == OP_ST_WORD);
        is_ldb    = req_valid && (req_op == OP_LD_BYTE);
        is_stb    = req_valid && (req_op == OP_ST_BYTE);
        word_op   = is_ldw || is_stw;
        bad_align = ea[1:0] != 2'b00;
        misalign  = word_op && bad_align;
        load_go   = is_ldb || (is_ldw && !bad_align);
        load_is_byte = is_ldb;
        byte_we   = 4'b0000;
        wr_data   = store_data;
        if (is_stw && !bad_align) begin
            byte_we = 4'b1111;
        end else if (is_stb) begin
            byte_we = lane_strobe(ea[1:0]);
            wr_data = {4{store_data[7:0]}};
        end
    end

    p_one_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_ST_BYTE) |-> $countones(byte_we) == 1);
    p_no_write_misaligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> byte_we == 4'b0000);
    p_byte_never_misaligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == OP_LD_BYTE || req_op == OP_ST_BYTE)) |-> !misalign);
endmodule

// File: rtl/lsu_word_ram.sv
// Module: lsu_word_ram
// Word-organised synchronous RAM with per-byte write strobes and a
// registered read port.
// Assumes the read and the write of one cycle go to the same index. A read
// returns the contents from before that edge. The contents are not reset.
module lsu_word_ram #(
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic [3:0]    we,
    input  logic [31:0]   wdata,
    input  logic          rd_en,
    output logic [31:0]   rdata
);
    localparam int unsigned DEPTH = 1 << AW;
    logic [31:0] mem [DEPTH];

    // Purpose: write the strobed lanes and register the read word.
    always_ff @(posedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (we[i]) mem[addr][8*i +: 8] <= wdata[8*i +: 8];
        end
        if (rd_en) rdata <= mem[addr];
    end
endmodule

// File: rtl/lsu_load_align.sv
// Module: lsu_load_align
// Registers the lane and size of a load and extracts the returned byte or
// word from the RAM word. A byte is sign-extended.
// Assumes the RAM word arrives one cycle after the request.
module lsu_load_align (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_go,
    input  logic        is_byte,
    input  logic [1:0]  lane,
    input  logic [31:0] rdata,
    output logic        valid,
    output logic [31:0] data
);
    logic       byte_q;
    logic [1:0] lane_q;
    logic [7:0] sel;

    // Purpose: hold the load attributes for the cycle in which the data returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            byte_q <= 1'b0;
            lane_q <= 2'b00;
        end else begin
            valid  <= load_go;
            byte_q <= is_byte;
            lane_q <= lane;
        end
    end

    // Purpose: pick the big-endian lane and extend it.
    always_comb begin
        case (lane_q)
            2'd0:    sel = rdata[31:24];
            2'd1:    sel = rdata[23:16];
            2'd2:    sel = rdata[15:8];
            default: sel = rdata[7:0];
        endcase
        data = byte_q ? {{24{sel[7]}}, sel} : rdata;
    end

    p_byte_sext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && byte_q) |-> data[31:8] == {24{data[7]}});
endmodule

// File: rtl/lsu_be_top.sv
// Module: lsu_be_top
// Big-endian load-store unit with an internal word RAM. Connects address
// generation, the RAM and load alignment.
// Assumes one request per cycle and no back-pressure.
module lsu_be_top #(
    parameter int unsigned AW = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [5:0]  req_op,
    input  logic [31:0] base_val,
    input  logic [15:0] offset_imm,
    input  logic [31:0] store_data,
    output logic [31:0] eff_addr,
    output logic [3:0]  mem_byte_we,
    output logic        misaligned,
    output logic        load_valid,
    output logic [31:0] load_data
);
    logic [31:0] wr_data, rd_word;
    logic        load_go, load_is_byte;

    lsu_addr_gen u_agen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .base_val(base_val), .offset_imm(offset_imm), .store_data(store_data),
        .ea(eff_addr), .byte_we(mem_byte_we), .wr_data(wr_data),
        .misalign(misaligned), .load_go(load_go), .load_is_byte(load_is_byte)
    );

    lsu_word_ram #(.AW(AW)) u_ram (
        .clk(clk), .addr(eff_addr[AW+1:2]), .we(mem_byte_we),
        .wdata(wr_data), .rd_en(load_go), .rdata(rd_word)
    );

    lsu_load_align u_align (
        .clk(clk), .rst_n(rst_n), .load_go(load_go), .is_byte(load_is_byte),
        .lane(eff_addr[1:0]), .rdata(rd_word), .valid(load_valid), .data(load_data)
    );

    p_load_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == 6'd32 || (req_op == 6'd35 && eff_addr[1:0] == 2'b00)))
        |=> load_valid);
    p_idle_no_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !load_valid);
endmodule

// File: tb/lsu_be_top_tb.sv
module lsu_be_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [5:0]  req_op = 6'd0;
    logic [31:0] base_val = 32'd0;
    logic [15:0] offset_imm = 16'd0;
    logic [31:0] store_data = 32'd0;
    logic [31:0] eff_addr;
    logic [3:0]  mem_byte_we;
    logic        misaligned, load_valid;
    logic [31:0] load_data;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lsu_be_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .base_val(base_val), .offset_imm(offset_imm), .store_data(store_data),
        .eff_addr(eff_addr), .mem_byte_we(mem_byte_we), .misaligned(misaligned),
        .load_valid(load_valid), .load_data(load_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive a request at the falling edge; sample the combinational outputs 1 ns later.
    task automatic drive(input logic [5:0] op, input logic [31:0] b, input logic [15:0] o,
                         input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; base_val = b; offset_imm = o; store_data = d;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        #1;
    endtask

    task automatic store(input string req, input logic [5:0] op, input logic [31:0] b,
                         input logic [15:0] o, input logic [31:0] d, input logic [3:0] exp_we);
        drive(op, b, o, d);
        check(req, {28'd0, mem_byte_we}, {28'd0, exp_we});
        idle();
    endtask

    task automatic load(input string req, input logic [5:0] op, input logic [31:0] b,
                        input logic [15:0] o, input logic [31:0] exp);
        drive(op, b, o, 32'd0);
        idle();
        check({req, " valid"}, {31'd0, load_valid}, 32'd1);
        check({req, " data"}, load_data, exp);
    endtask

    task automatic t_reset();
        check("R8 load_valid", {31'd0, load_valid}, 32'd0);
        check("R8 misaligned", {31'd0, misaligned}, 32'd0);
        check("R8 strobes", {28'd0, mem_byte_we}, 32'd0);
    endtask

    task automatic t_word();
        drive(6'd43, 32'h0000_0100, 16'hFFFC, 32'hCAFE_0001);
        check("R1 eff_addr negative offset", eff_addr, 32'h0000_00FC);
        check("R5 word strobes", {28'd0, mem_byte_we}, 32'hF);
        idle();
        store("R5 word store", 6'd43, 32'h0000_0010, 16'h0004, 32'h1234_5678, 4'hF);
        load("R5 word load neg", 6'd35, 32'h0000_00F0, 16'h000C, 32'hCAFE_0001);
        load("R5 word load", 6'd35, 32'h0000_0000, 16'h0014, 32'h1234_5678);
        @(negedge clk);
        check("R7 single-cycle valid", {31'd0, load_valid}, 32'd0);
    endtask

    task automatic t_byte_store();
        store("R5 setup", 6'd43, 32'h20, 16'h0, 32'h1122_3344, 4'hF);
        store("R4 offset1 strobe", 6'd40, 32'h20, 16'h1, 32'hFFFF_FFAB, 4'b0100);
        load("R4 neighbours kept", 6'd35, 32'h20, 16'h0, 32'h11AB_3344);
        store("R4 offset3 strobe", 6'd40, 32'h23, 16'h0, 32'h0000_00CD, 4'b0001);
        store("R4 offset0 strobe", 6'd40, 32'h1F, 16'h1, 32'h0000_00EF, 4'b1000);
        load("R4 lanes 0 and 3", 6'd35, 32'h20, 16'h0, 32'hEFAB_33CD);
    endtask

    task automatic t_byte_load();
        store("R5 setup", 6'd43, 32'h40, 16'h0, 32'h80FF_7F01, 4'hF);
        load("R3 offset0 sign", 6'd32, 32'h40, 16'h0, 32'hFFFF_FF80);
        load("R3 offset1 sign", 6'd32, 32'h40, 16'h1, 32'hFFFF_FFFF);
        load("R3 offset2 positive", 6'd32, 32'h40, 16'h2, 32'h0000_007F);
        load("R3 offset3 positive", 6'd32, 32'h44, 16'hFFFF, 32'h0000_0001);
        drive(6'd32, 32'h43, 16'h0, 32'h0);
        check("R9 byte offset3 not misaligned", {31'd0, misaligned}, 32'd0);
        idle();
    endtask

    task automatic t_misalign();
        drive(6'd43, 32'h40, 16'h2, 32'hDEAD_BEEF);
        check("R6 store flag", {31'd0, misaligned}, 32'd1);
        check("R6 store no strobes", {28'd0, mem_byte_we}, 32'd0);
        idle();
        drive(6'd35, 32'h41, 16'h0, 32'h0);
        check("R6 load flag", {31'd0, misaligned}, 32'd1);
        idle();
        check("R6 no load result", {31'd0, load_valid}, 32'd0);
        load("R6 memory intact", 6'd35, 32'h40, 16'h0, 32'h80FF_7F01);
    endtask

    task automatic t_bad_op();
        drive(6'd13, 32'h40, 16'h0, 32'h0BAD_0BAD);
        check("R2 unknown op strobes", {28'd0, mem_byte_we}, 32'd0);
        idle();
        check("R2 unknown op no result", {31'd0, load_valid}, 32'd0);
        load("R2 memory intact", 6'd35, 32'h40, 16'h0, 32'h80FF_7F01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_word();
        t_byte_store();
        t_byte_load();
        t_misalign();
        t_bad_op();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule